// File: doc/BRIEF.md
# Accumulator Processor Core with Fetch-Decode-Execute Sequencer

This block is a small processor core with a single accumulator. It works through a fixed register-transfer sequence: program counter, memory address register, memory data register, current-instruction register and accumulator. Instructions and data share one memory. That memory is reached through one synchronous port, and a read on that port returns its word one clock after the request. The core steps through one state per clock and completes one instruction before it starts the next.

Every instruction word is 16 bits wide. Bits 15:12 hold the opcode and bits 11:0 hold an address operand. The opcodes are:

- 0: halt
- 1: load
- 2: store
- 3: add
- 4: subtract
- 5: AND
- 6: shift left by one
- 7: jump

Values 8 to 15 do nothing. Every address sent to memory comes from the address register. Every word read from memory passes through the data register.

Top module: `acc_core`

## Requirements
- R1: While reset is low, mem_rd, mem_we and halted are low. After reset the accumulator reads zero, and the first fetch reads address 0.
- R2: A fetch copies the PC into the address register. In the next cycle it raises mem_rd for one cycle at that address and increments the PC. The data register captures the word one cycle later, and the instruction register takes it one cycle after that. A non-memory instruction then takes 6 cycles in total.
- R3: Load (1), add (3), subtract (4) and AND (5) perform a second read at the operand address, bits 11:0. Each of these instructions takes 8 cycles.
- R4: Load replaces the accumulator with the memory word. Add and subtract work modulo 2^16. AND is bitwise.
- R5: Shift (6) moves the accumulator left by one bit. It fills with zero, drops the top bit and does not read memory.
- R6: Store (2) drives mem_we for exactly one cycle. It writes the accumulator to the operand address, 6 cycles per instruction.
- R7: Jump (7) makes the next fetch read the operand address.
- R8: Halt (0) raises halted. From then until reset, halted stays high and mem_rd and mem_we stay low.
- R9: Opcodes 8 to 15 leave the accumulator and memory unchanged, and each takes 6 cycles.
- R10: The PC wraps from 0xFFF to 0x000.
- R11: mem_rd and mem_we are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 12 | Memory address, always the address register |
| mem_rd | output | 1 | Read request; data is expected on mem_rdata one cycle later |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data, the accumulator |
| mem_rdata | input | 16 | Read data from the previous cycle's request |
| halted | output | 1 | High once a halt has executed |

## Verification
The embedded assertions check several properties on every cycle:
- the PC steps by one, with wrap, on every fetch read;
- the instruction register takes the data register's value;
- a jump loads the PC from the operand;
- a halt stays final and silent;
- a store strobe lasts one cycle;
- reads and writes never overlap.

Some behaviour can only be shown by the bench's scenarios, which compare the core against an instruction-level model:
- the arithmetic results seen through stored words;
- the order of memory reads;
- the exact cycle count of each program;
- the PC wrap and self-modifying code through the shared memory.

// File: rtl/acc_pkg.sv
package acc_pkg;

  localparam int OPC_W = 4;

  typedef enum logic [OPC_W-1:0] {
    OP_HALT  = 4'd0,
    OP_LOAD  = 4'd1,
    OP_STORE = 4'd2,
    OP_ADD   = 4'd3,
    OP_SUB   = 4'd4,
    OP_AND   = 4'd5,
    OP_SHL   = 4'd6,
    OP_JUMP  = 4'd7
  } opcode_e;

  typedef enum logic [3:0] {
    ST_FETCH,
    ST_FREAD,
    ST_FCAP,
    ST_XFER,
    ST_DECODE,
    ST_DREAD,
    ST_DCAP,
    ST_EXEC,
    ST_HALT
  } state_e;

  // Instruction needs a data word from memory before execute
  function automatic logic op_reads_mem(opcode_e op);
    return (op == OP_LOAD) || (op == OP_ADD) || (op == OP_SUB) || (op == OP_AND);
  endfunction

  // Instruction places its operand in the address register during decode
  function automatic logic op_uses_addr(opcode_e op);
    return op_reads_mem(op) || (op == OP_STORE);
  endfunction

  // Instruction updates the accumulator in execute
  function automatic logic op_writes_acc(opcode_e op);
    return op_reads_mem(op) || (op == OP_SHL);
  endfunction

endpackage

// File: rtl/acc_alu.sv
module acc_alu
  import acc_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  opcode_e           op,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] mdr,
  output logic [DATA_W-1:0] result
);

  function automatic logic [DATA_W-1:0] alu_eval(
    opcode_e f_op,
    logic [DATA_W-1:0] a,
    logic [DATA_W-1:0] b
  );
    logic [DATA_W-1:0] r;
    case (f_op)
      OP_LOAD: r = b;
      OP_ADD:  r = a + b;
      OP_SUB:  r = a - b;
      OP_AND:  r = a & b;
      OP_SHL:  r = {a[DATA_W-2:0], 1'b0};
      default: r = a;
    endcase
    return r;
  endfunction

  assign result = alu_eval(op, acc, mdr);

endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  opcode_e op,
  output state_e  st,
  output logic    mar_from_pc,
  output logic    mar_from_opd,
  output logic    rd,
  output logic    we,
  output logic    pc_inc,
  output logic    mdr_ld,
  output logic    cir_ld,
  output logic    acc_ld,
  output logic    pc_jmp,
  output logic    halted
);

  state_e st_q, st_d;

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_FETCH;
    else        st_q <= st_d;
  end

  always_comb begin
    st_d         = st_q;
    mar_from_pc  = 1'b0;
    mar_from_opd = 1'b0;
    rd           = 1'b0;
    we           = 1'b0;
    pc_inc       = 1'b0;
    mdr_ld       = 1'b0;
    cir_ld       = 1'b0;
    acc_ld       = 1'b0;
    pc_jmp       = 1'b0;
    case (st_q)
      ST_FETCH: begin
        mar_from_pc = 1'b1;
        st_d        = ST_FREAD;
      end
      ST_FREAD: begin
        rd     = 1'b1;
        pc_inc = 1'b1;
        st_d   = ST_FCAP;
      end
      ST_FCAP: begin
        mdr_ld = 1'b1;
        st_d   = ST_XFER;
      end
      ST_XFER: begin
        cir_ld = 1'b1;
        st_d   = ST_DECODE;
      end
      ST_DECODE: begin
        mar_from_opd = op_uses_addr(op);
        st_d         = op_reads_mem(op) ? ST_DREAD : ST_EXEC;
      end
      ST_DREAD: begin
        rd   = 1'b1;
        st_d = ST_DCAP;
      end
      ST_DCAP: begin
        mdr_ld = 1'b1;
        st_d   = ST_EXEC;
      end
      ST_EXEC: begin
        we     = (op == OP_STORE);
        pc_jmp = (op == OP_JUMP);
        acc_ld = op_writes_acc(op);
        st_d   = (op == OP_HALT) ? ST_HALT : ST_FETCH;
      end
      ST_HALT: st_d = ST_HALT;
      default: st_d = ST_FETCH;
    endcase
  end

  assign st     = st_q;
  assign halted = (st_q == ST_HALT);

  // R11
  rd_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd && we));

  // R8
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  // R8
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!rd && !we));

  // R6
  store_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> !we);

endmodule

// File: rtl/acc_datapath.sv
module acc_datapath #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mar_from_pc,
  input  logic              mar_from_opd,
  input  logic              pc_inc,
  input  logic              mdr_ld,
  input  logic              cir_ld,
  input  logic              acc_ld,
  input  logic              pc_jmp,
  input  logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] alu_res,
  output logic [ADDR_W-1:0] mar,
  output logic [DATA_W-1:0] mdr,
  output logic [DATA_W-1:0] cir,
  output logic [DATA_W-1:0] acc
);

  logic [ADDR_W-1:0] pc_q, mar_q;
  logic [DATA_W-1:0] mdr_q, cir_q, acc_q;
  logic [ADDR_W-1:0] opd;

  assign opd = cir_q[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q  <= '0;
      mar_q <= '0;
      mdr_q <= '0;
      cir_q <= '0;
      acc_q <= '0;
    end else begin
      if (pc_jmp)      pc_q <= opd;
      else if (pc_inc) pc_q <= pc_q + ADDR_W'(1);
      if (mar_from_pc)       mar_q <= pc_q;
      else if (mar_from_opd) mar_q <= opd;
      if (mdr_ld) mdr_q <= rdata;
      if (cir_ld) cir_q <= mdr_q;
      if (acc_ld) acc_q <= alu_res;
    end
  end

  assign mar = mar_q;
  assign mdr = mdr_q;
  assign cir = cir_q;
  assign acc = acc_q;

  // R2 R10
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_inc |=> (pc_q == ADDR_W'($past(pc_q) + 1'b1)));

  // R2
  cir_from_mdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cir_ld |=> (cir_q == $past(mdr_q)));

  // R7
  jump_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_jmp |=> (pc_q == $past(cir_q[ADDR_W-1:0])));

  // R2
  fetch_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mar_from_pc |=> (mar_q == $past(pc_q)));

endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = DATA_W - OPC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              halted
);

  state_e            st;
  opcode_e           op;
  logic              mar_from_pc, mar_from_opd, pc_inc, mdr_ld, cir_ld, acc_ld, pc_jmp;
  logic [ADDR_W-1:0] mar;
  logic [DATA_W-1:0] mdr, cir, acc, alu_res;

  assign op = opcode_e'(cir[DATA_W-1 -: OPC_W]);

  acc_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .op           (op),
    .st           (st),
    .mar_from_pc  (mar_from_pc),
    .mar_from_opd (mar_from_opd),
    .rd           (mem_rd),
    .we           (mem_we),
    .pc_inc       (pc_inc),
    .mdr_ld       (mdr_ld),
    .cir_ld       (cir_ld),
    .acc_ld       (acc_ld),
    .pc_jmp       (pc_jmp),
    .halted       (halted)
  );

  acc_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .mar_from_pc  (mar_from_pc),
    .mar_from_opd (mar_from_opd),
    .pc_inc       (pc_inc),
    .mdr_ld       (mdr_ld),
    .cir_ld       (cir_ld),
    .acc_ld       (acc_ld),
    .pc_jmp       (pc_jmp),
    .rdata        (mem_rdata),
    .alu_res      (alu_res),
    .mar          (mar),
    .mdr          (mdr),
    .cir          (cir),
    .acc          (acc)
  );

  acc_alu #(.DATA_W(DATA_W)) u_alu (
    .op     (op),
    .acc    (acc),
    .mdr    (mdr),
    .result (alu_res)
  );

  assign mem_addr  = mar;
  assign mem_wdata = acc;

  // R3
  data_read_in_dread_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && st == ST_DREAD) |-> (mem_addr == cir[ADDR_W-1:0]));

endmodule

// File: tb/sim_acc_core.sv
module sim_acc_core;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] mem_addr;
  logic        mem_rd, mem_we, halted;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;

  always #5 clk = ~clk;

  acc_core u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .halted    (halted)
  );

  logic [15:0] mem [4096];
  logic [15:0] mm  [4096];
  int checks = 0;
  int fails = 0;
  int cyc = 0;
  logic logging = 1'b0;
  int rd_log[$];
  int wr_log[$];
  int exp_rd[$];
  int exp_wr[$];

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr];
    if (mem_we) mem[mem_addr] <= mem_wdata;
    cyc <= cyc + 1;
  end

  always @(negedge clk) begin
    if (rst_n && logging) begin
      if (mem_rd) rd_log.push_back(int'(mem_addr));
      if (mem_we) wr_log.push_back(int'({mem_addr, mem_wdata}));
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] ins(input int op, input int opd);
    return {4'(op), 12'(opd)};
  endfunction

  // Instruction-level model of the requirements
  task automatic run_model(output int cycles);
    int pc = 0;
    logic [15:0] acc = '0;
    logic [15:0] w;
    int op, opd;
    cycles = 0;
    exp_rd.delete();
    exp_wr.delete();
    for (int step = 0; step < 3000; step++) begin
      exp_rd.push_back(pc);
      w = mm[pc];
      pc = (pc + 1) % 4096;
      op = int'(w[15:12]);
      opd = int'(w[11:0]);
      cycles += 6;
      if (op == 1 || op == 3 || op == 4 || op == 5) begin
        exp_rd.push_back(opd);
        cycles += 2;
        case (op)
          1: acc = mm[opd];
          3: acc = acc + mm[opd];
          4: acc = acc - mm[opd];
          default: acc = acc & mm[opd];
        endcase
      end else if (op == 2) begin
        mm[opd] = acc;
        exp_wr.push_back(int'({12'(opd), acc}));
      end else if (op == 6) begin
        acc = acc << 1;
      end else if (op == 7) begin
        pc = opd;
      end else if (op == 0) begin
        break;
      end
    end
  endtask

  task automatic run_prog(input string req);
    int exp_cyc, n;
    bit ok;
    int quiet;
    for (int i = 0; i < 4096; i++) mm[i] = mem[i];
    run_model(exp_cyc);
    rd_log.delete();
    wr_log.delete();
    @(negedge clk);
    rst_n = 1'b0;
    logging = 1'b1;
    @(negedge clk);
    @(negedge clk);
    // R1: outputs quiet during reset
    check(!mem_rd && !mem_we && !halted, "R1", "outputs in reset",
          int'({mem_rd, mem_we, halted}), 0);
    rst_n = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!halted && n < 5000);
    check(n == exp_cyc, req, "cycles to halt", n, exp_cyc);
    ok = (rd_log.size() == exp_rd.size());
    for (int i = 0; ok && i < rd_log.size(); i++) ok = (rd_log[i] == exp_rd[i]);
    check(ok, req, "read address order",
          rd_log.size() > 0 ? rd_log[0] : -1, exp_rd.size() > 0 ? exp_rd[0] : -1);
    ok = (wr_log.size() == exp_wr.size());
    for (int i = 0; ok && i < wr_log.size(); i++) ok = (wr_log[i] == exp_wr[i]);
    check(ok, req, "store address/data", wr_log.size(), exp_wr.size());
    quiet = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (mem_rd || mem_we || !halted) quiet++;
    end
    // R8
    check(quiet == 0, "R8", "activity after halt", quiet, 0);
    logging = 1'b0;
  endtask

  initial begin
    int a, r;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4096; i++) mem[i] = '0;

    // R1 R8: halt at address 0 straight after reset
    run_prog("R1 R8");

    // R4 R5 R6 R9: directed arithmetic corners
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    mem[12'h100] = 16'hFFF0; mem[12'h101] = 16'h0020;
    mem[12'h102] = 16'h0100; mem[12'h103] = 16'h0F0F;
    a = 0;
    mem[a++] = ins(1, 12'h100); mem[a++] = ins(3, 12'h101); mem[a++] = ins(2, 12'h110);
    mem[a++] = ins(4, 12'h102); mem[a++] = ins(2, 12'h111);
    mem[a++] = ins(5, 12'h103); mem[a++] = ins(2, 12'h112);
    mem[a++] = ins(1, 12'h100); mem[a++] = ins(6, 0);       mem[a++] = ins(2, 12'h113);
    mem[a++] = ins(9, 12'h100); mem[a++] = ins(15, 12'h101); mem[a++] = ins(2, 12'h114);
    mem[a++] = ins(0, 0);
    run_prog("R4 R5 R6 R9");
    check(mem[12'h110] == 16'h0010, "R4", "add wrap", int'(mem[12'h110]), 16'h0010);
    check(mem[12'h111] == 16'hFF10, "R4", "sub wrap", int'(mem[12'h111]), 16'hFF10);
    check(mem[12'h113] == 16'hFFE0, "R5", "shift drops msb", int'(mem[12'h113]), 16'hFFE0);
    check(mem[12'h114] == 16'hFFE0, "R9", "unused opcode no-op", int'(mem[12'h114]), 16'hFFE0);

    // R7 R10: jump to the last address, store halt word over address 0, wrap
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    mem[0] = ins(7, 12'hFFF);
    mem[12'hFFF] = ins(2, 12'h000);
    run_prog("R7 R10");
    check(mem[0] == 16'h0000, "R10", "wrapped store target", int'(mem[0]), 0);

    // R2 R3 R4 R5 R6 R7 R9: random programs
    for (int p = 0; p < 30; p++) begin
      for (int i = 0; i < 4096; i++) mem[i] = '0;
      for (int i = 0; i < 16; i++) mem[12'h100 + i] = 16'($urandom);
      a = 0;
      for (int k = 0; k < 24; k++) begin
        r = int'($urandom % 10);
        case (r)
          0, 1: mem[a++] = ins(1, 12'h100 + int'($urandom % 16));
          2: mem[a++] = ins(3, 12'h100 + int'($urandom % 16));
          3: mem[a++] = ins(4, 12'h100 + int'($urandom % 16));
          4: mem[a++] = ins(5, 12'h100 + int'($urandom % 16));
          5: mem[a++] = ins(6, int'($urandom % 4096));
          6, 7: mem[a++] = ins(2, 12'h100 + int'($urandom % 16));
          8: mem[a++] = ins(8 + int'($urandom % 8), int'($urandom % 4096));
          default: begin
            mem[a] = ins(7, a + 2);
            mem[a + 1] = ins(2, 12'h1F0);
            a += 2;
          end
        endcase
      end
      mem[a] = ins(0, 0);
      run_prog("R2 R3 R4 R5 R6 R7 R9");
      for (int i = 0; i < 16; i++)
        check(mem[12'h100 + i] == mm[12'h100 + i], "R6", "final data word",
              int'(mem[12'h100 + i]), int'(mm[12'h100 + i]));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  // Watchdog
  initial begin
    wait (cyc > 190000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected below 190000", cyc);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule